// File: doc/BRIEF.md
# Two-Bank Quad-Word Burst Static Memory

This block is a synthesizable behavioural model of a synchronous static memory built from two banks that share one address, one control set and one 72-bit word path. Every control and address input is captured on the rising clock edge. Each captured cycle is classified as an idle or deselect cycle, the start of a burst, the next beat of a burst, or a held (wait) beat. Every beat except idle is either a read or a write. A burst covers four words. Its two lowest address bits come from an internal beat counter that steps in linear or in interleaved order. The upper address bits stay at the value captured when the burst started.

Two address strobes start bursts. The processor strobe only starts reads, and only when at least one bank enable is asserted. The controller strobe starts a read or a write according to the write input, or deselects both banks when no enable is asserted. Reads are flow-through: the word at the captured address appears on the output in the cycle that follows the capturing edge, with no output register. The output enable and the two per-bank sleep inputs act on the output without waiting for a clock edge. A write is stored at the same edge that captures it.

The cycle classifier is a state machine with these states. S_IDLE: no burst is open, after reset or after a deselect. S_RD_BEGIN and S_WR_BEGIN: a burst starts at the external address. S_RD_NEXT and S_WR_NEXT: the counter advances by one beat. S_RD_HOLD and S_WR_HOLD: the address is reused. The transitions are checked in this priority order:
- T_PSTART: processor strobe with an enable goes to S_RD_BEGIN.
- T_CSTART: controller strobe with an enable goes to S_RD_BEGIN or S_WR_BEGIN.
- T_DESEL: controller strobe with no enable goes to S_IDLE.
- T_STAY: no strobe while in S_IDLE stays in S_IDLE.
- T_ADV: no strobe, advance low, goes to a NEXT state.
- T_WAIT: no strobe, advance high, goes to a HOLD state.

In the last two transitions the write input picks the read or the write variant.

Top module: `qburst_sram`

## Requirements
- R1: After reset the block is in S_IDLE with the output not driven (data_oe_o = 0). Advance or hold cycles issued without a strobe leave the output undriven and store nothing.
- R2: With pstrb_n_i low and at least one bank_en_n_i bit low, the external address is captured and a read begins. wr_n_i and data_i are ignored in that cycle. The addressed word is on data_o in the cycle after that edge.
- R3: With cstrb_n_i low, pstrb_n_i high and at least one bank_en_n_i bit low, the external address is captured. wr_n_i low starts a write burst that stores data_i at that edge. wr_n_i high starts a read burst.
- R4: With cstrb_n_i low and both bank_en_n_i bits high, the cycle is a deselect. The output is undriven, and later cycles without a strobe neither drive nor store until a new burst starts.
- R5: With both strobes high and adv_n_i low during an open burst, the beat counter steps by one. wr_n_i low stores data_i at the new address. wr_n_i high reads it.
- R6: With both strobes high and adv_n_i high during an open burst, the address and counter are held. A read shows the same word again, and a write stores to the same address.
- R7: With order_sel_i = 0 (linear), beat k of a burst starting at address S uses low bits (S[1:0] + k) mod 4. Bits above bit 1 stay equal to those of S.
- R8: With order_sel_i = 1 (interleaved), beat k uses low bits S[1:0] XOR k. Upper bits are kept as in R7.
- R9: The fifth beat of a burst (after four steps) returns to the start address.
- R10: oe_n_i is active low and acts without a clock edge: a read with oe_n_i high leaves the output undriven. Write cycles never drive the output.
- R11: A word is 72 bits. Data byte k occupies bits [8k+7:8k] for k = 0..7, and the parity bit of byte k is bit 64+k. All 72 bits are stored and returned unchanged.
- R12: sleep_i[b] high makes bank b ignore writes and keeps the output undriven while that bank is selected. Clearing sleep_i[b] restores the output in the same cycle, without a clock edge.
- R13: A burst start selects bank 0 when bank_en_n_i[0] is low, otherwise bank 1. That bank stays selected through next and hold beats whatever bank_en_n_i then is. The two banks hold separate data at equal addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls captured on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| addr_i | input | AW | Word address, AW = log2(DEPTH) |
| bank_en_n_i | input | 2 | Active-low bank enables, bit 0 for bank 0 |
| pstrb_n_i | input | 1 | Processor address strobe, active low, read only |
| cstrb_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low; high holds the beat |
| wr_n_i | input | 1 | Global write, active low |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| sleep_i | input | 2 | Asynchronous active-high per-bank sleep |
| data_i | input | 72 | Write word (64 data bits, 8 parity bits) |
| data_o | output | 72 | Read word, zero when not driven |
| data_oe_o | output | 1 | High when data_o is driven (low means high impedance) |

## Verification
A strobe, advance or hold cycle captured at a rising edge sets the address, and a read result shows up on data_o right after that edge, because reads pass through no output register. A write is stored at the capturing edge itself, so its effect is checked by a later read burst. The bench drives each cycle's inputs at the falling edge and samples 1 ns after the next rising edge, so every read beat is checked in the cycle it belongs to. oe_n_i and sleep_i need no edge, so the bench toggles them inside a cycle and samples 1 ns later, before the next edge.

// File: rtl/qb_pkg.sv
package qb_pkg;

    localparam int BANK_N = 2;
    localparam int LOW_W  = 2;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_RD_BEGIN = 3'd1,
        S_WR_BEGIN = 3'd2,
        S_RD_NEXT  = 3'd3,
        S_WR_NEXT  = 3'd4,
        S_RD_HOLD  = 3'd5,
        S_WR_HOLD  = 3'd6
    } qb_state_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } qb_cmd_e;

    // Low address bits for a given beat of a four-word burst.
    function automatic logic [LOW_W-1:0] beat_low(
        input logic [LOW_W-1:0] start,
        input logic [LOW_W-1:0] beat,
        input logic             interleaved
    );
        if (interleaved) begin
            return start ^ beat;
        end
        return start + beat;
    endfunction

endpackage

// File: rtl/qb_cycle_fsm.sv
module qb_cycle_fsm
    import qb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pstrb_n_i,
    input  logic       cstrb_n_i,
    input  logic       adv_n_i,
    input  logic       wr_n_i,
    input  logic [1:0] bank_en_n_i,
    output qb_state_e  state_q,
    output qb_cmd_e    addr_cmd_o,
    output logic       bank_q,
    output logic       bank_nxt_o,
    output logic       wr_nxt_o,
    output logic       rd_cycle_o,
    output logic       wr_cycle_o
);

    qb_state_e state_nxt;
    logic      bank_nxt;
    logic      any_en;

    assign any_en     = ~(&bank_en_n_i);
    assign bank_nxt_o = bank_nxt;

    // Next-state decision, strobes first, then advance / wait.
    always_comb begin
        state_nxt = state_q;
        bank_nxt  = bank_q;
        if (!pstrb_n_i && any_en) begin
            state_nxt = S_RD_BEGIN;                 // T_PSTART
            bank_nxt  = bank_en_n_i[0];
        end else if (!cstrb_n_i) begin
            if (any_en) begin
                state_nxt = wr_n_i ? S_RD_BEGIN : S_WR_BEGIN; // T_CSTART
                bank_nxt  = bank_en_n_i[0];
            end else begin
                state_nxt = S_IDLE;                 // T_DESEL
            end
        end else if (state_q == S_IDLE) begin
            state_nxt = S_IDLE;                     // T_STAY
        end else if (!adv_n_i) begin
            state_nxt = wr_n_i ? S_RD_NEXT : S_WR_NEXT; // T_ADV
        end else begin
            state_nxt = wr_n_i ? S_RD_HOLD : S_WR_HOLD; // T_WAIT
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            bank_q  <= bank_nxt;
        end
    end

    // Outputs: address command for the coming edge, cycle kind now.
    always_comb begin
        addr_cmd_o = CMD_HOLD;
        wr_nxt_o   = 1'b0;
        rd_cycle_o = 1'b0;
        wr_cycle_o = 1'b0;
        unique case (state_nxt)
            S_RD_BEGIN: addr_cmd_o = CMD_LOAD;
            S_WR_BEGIN: begin addr_cmd_o = CMD_LOAD; wr_nxt_o = 1'b1; end
            S_RD_NEXT:  addr_cmd_o = CMD_STEP;
            S_WR_NEXT:  begin addr_cmd_o = CMD_STEP; wr_nxt_o = 1'b1; end
            S_WR_HOLD:  wr_nxt_o = 1'b1;
            S_RD_HOLD, S_IDLE: addr_cmd_o = CMD_HOLD;
            default:    addr_cmd_o = CMD_HOLD;
        endcase
        unique case (state_q)
            S_RD_BEGIN, S_RD_NEXT, S_RD_HOLD: rd_cycle_o = 1'b1;
            S_WR_BEGIN, S_WR_NEXT, S_WR_HOLD: wr_cycle_o = 1'b1;
            S_IDLE:  rd_cycle_o = 1'b0;
            default: rd_cycle_o = 1'b0;
        endcase
    end

    // R2: a processor strobe with an enable always opens a read.
    a_r2_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstrb_n_i && any_en) |=> (state_q == S_RD_BEGIN));

    // R4 / R1: without a strobe an idle machine stays idle.
    a_r4_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && cstrb_n_i && (pstrb_n_i || !any_en))
        |=> (state_q == S_IDLE));

    // R13: the bank only changes when a burst starts.
    a_r13_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cstrb_n_i && (pstrb_n_i || !any_en)) |=> $stable(bank_q));

endmodule

// File: rtl/qb_burst_addr.sv
module qb_burst_addr
    import qb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  qb_cmd_e       cmd_i,
    input  logic          order_sel_i,
    input  logic [AW-1:0] ext_addr_i,
    output logic [AW-1:0] addr_nxt_o,
    output logic [AW-1:0] addr_q
);

    logic [LOW_W-1:0] start_q, start_nxt;
    logic [LOW_W-1:0] beat_q,  beat_nxt;

    always_comb begin
        start_nxt  = start_q;
        beat_nxt   = beat_q;
        addr_nxt_o = addr_q;
        unique case (cmd_i)
            CMD_LOAD: begin
                start_nxt  = ext_addr_i[LOW_W-1:0];
                beat_nxt   = '0;
                addr_nxt_o = ext_addr_i;
            end
            CMD_STEP: begin
                beat_nxt   = beat_q + 1'b1;
                addr_nxt_o = {addr_q[AW-1:LOW_W],
                              beat_low(start_q, beat_nxt, order_sel_i)};
            end
            CMD_HOLD: addr_nxt_o = addr_q;
            default:  addr_nxt_o = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
            addr_q  <= '0;
        end else begin
            start_q <= start_nxt;
            beat_q  <= beat_nxt;
            addr_q  <= addr_nxt_o;
        end
    end

    // R6: a held beat keeps the address.
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_HOLD) |=> $stable(addr_q));

    // R7: stepping never touches the upper address bits.
    a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_STEP) |=> (addr_q[AW-1:LOW_W] == $past(addr_q[AW-1:LOW_W])));

    // R5: stepping always moves to a different word of the quad.
    a_r5_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_STEP) |=> (addr_q[LOW_W-1:0] != $past(addr_q[LOW_W-1:0])));

endmodule

// File: rtl/qb_bank_array.sv
module qb_bank_array
    import qb_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 72,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic [BANK_N-1:0] wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_bank_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o
);

    logic [WORD_W-1:0] bank_rd [BANK_N];

    for (genvar b = 0; b < BANK_N; b++) begin : g_bank
        logic [WORD_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en_i[b]) begin
                mem[wr_addr_i] <= wr_data_i;
            end
        end

        assign bank_rd[b] = mem[rd_addr_i];
    end

    assign rd_data_o = bank_rd[rd_bank_i];

endmodule

// File: rtl/qburst_sram.sv
module qburst_sram
    import qb_pkg::*;
#(
    parameter  int DEPTH      = 64,
    parameter  int DATA_BYTES = 8,
    localparam int AW         = $clog2(DEPTH),
    localparam int WORD_W     = DATA_BYTES * 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr_i,
    input  logic [1:0]        bank_en_n_i,
    input  logic              pstrb_n_i,
    input  logic              cstrb_n_i,
    input  logic              adv_n_i,
    input  logic              wr_n_i,
    input  logic              order_sel_i,
    input  logic              oe_n_i,
    input  logic [1:0]        sleep_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] data_o,
    output logic              data_oe_o
);

    qb_state_e         state_q;
    qb_cmd_e           addr_cmd;
    logic              bank_q;
    logic              bank_nxt;
    logic              wr_nxt;
    logic              rd_cycle;
    logic              wr_cycle;
    logic [AW-1:0]     addr_nxt;
    logic [AW-1:0]     addr_q;
    logic [BANK_N-1:0] bank_wr;
    logic [WORD_W-1:0] rd_word;

    qb_cycle_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pstrb_n_i   (pstrb_n_i),
        .cstrb_n_i   (cstrb_n_i),
        .adv_n_i     (adv_n_i),
        .wr_n_i      (wr_n_i),
        .bank_en_n_i (bank_en_n_i),
        .state_q     (state_q),
        .addr_cmd_o  (addr_cmd),
        .bank_q      (bank_q),
        .bank_nxt_o  (bank_nxt),
        .wr_nxt_o    (wr_nxt),
        .rd_cycle_o  (rd_cycle),
        .wr_cycle_o  (wr_cycle)
    );

    qb_burst_addr #(.AW(AW)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (addr_cmd),
        .order_sel_i (order_sel_i),
        .ext_addr_i  (addr_i),
        .addr_nxt_o  (addr_nxt),
        .addr_q      (addr_q)
    );

    // A write lands at the capturing edge unless reset or the bank sleeps.
    for (genvar b = 0; b < BANK_N; b++) begin : g_wsel
        assign bank_wr[b] = rst_n && wr_nxt && (bank_nxt == 1'(b)) && !sleep_i[b];
    end

    qb_bank_array #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW)) u_array (
        .clk       (clk),
        .wr_en_i   (bank_wr),
        .wr_addr_i (addr_nxt),
        .wr_data_i (data_i),
        .rd_bank_i (bank_q),
        .rd_addr_i (addr_q),
        .rd_data_o (rd_word)
    );

    // Flow-through read path, gated by the asynchronous enables.
    always_comb begin
        data_oe_o = rd_cycle && !oe_n_i && !sleep_i[bank_q];
        data_o    = data_oe_o ? rd_word : '0;
    end

    // R10: write beats never drive the output.
    a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cycle |-> !data_oe_o);

    // R1: right after reset the output is undriven.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !data_oe_o);

endmodule

// File: tb/qburst_sram_test.sv
module qburst_sram_test;

    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int WW    = 72;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [1:0]    en_n;
    logic          pstrb_n, cstrb_n, adv_n, wr_n, order_sel, oe_n;
    logic [1:0]    sleep;
    logic [WW-1:0] din, dout;
    logic          dout_en;

    always #5 clk = ~clk;

    qburst_sram #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .bank_en_n_i(en_n),
        .pstrb_n_i(pstrb_n), .cstrb_n_i(cstrb_n), .adv_n_i(adv_n),
        .wr_n_i(wr_n), .order_sel_i(order_sel), .oe_n_i(oe_n),
        .sleep_i(sleep), .data_i(din), .data_o(dout), .data_oe_o(dout_en)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [WW-1:0] ref_mem [2][DEPTH];

    function automatic logic [WW-1:0] pat(int b, int ad, int tag);
        return {8'(tag) ^ 8'h5A, 24'(tag * 3 + 1), 8'(b), 16'(ad), 16'hBEEF};
    endfunction

    // R7/R8 address rule, computed independently.
    function automatic int beat_addr(int s, int k, bit m);
        int lo;
        lo = m ? ((s & 3) ^ (k & 3)) : ((s + k) & 3);
        return (s & ~3) | lo;
    endfunction

    function automatic logic [1:0] en_of(int b);
        return (b == 0) ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(bit ok, string r, logic [WW-1:0] act, logic [WW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic cyc(logic p, logic c, logic a, logic w, logic [1:0] en,
                       int ad, logic [WW-1:0] d);
        @(negedge clk);
        pstrb_n = p; cstrb_n = c; adv_n = a; wr_n = w;
        en_n = en; addr = AW'(ad); din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_read(int b, int ad, string r);
        chk(dout_en === 1'b1 && dout === ref_mem[b][ad], r, dout, ref_mem[b][ad]);
    endtask

    task automatic expect_quiet(string r);
        chk(dout_en === 1'b0, r, WW'(dout_en), '0);
    endtask

    task automatic wr_burst(int b, int s, bit m, int tag, string r);
        order_sel = m;
        for (int k = 0; k < 4; k++) begin
            int ad;
            logic [WW-1:0] d;
            ad = beat_addr(s, k, m);
            d  = pat(b, ad, tag + k);
            if (k == 0) cyc(1, 0, 1, 0, en_of(b), s, d);
            else        cyc(1, 1, 0, 0, 2'b11, 0, d);
            if (!sleep[b]) ref_mem[b][ad] = d;
            expect_quiet({r, " R10 write beat undriven"});
        end
    endtask

    task automatic rd_burst(int b, int s, bit m, int nbeats, bit via_p, string r);
        order_sel = m;
        if (via_p) cyc(0, 1, 1, 1, en_of(b), s, '0);
        else       cyc(1, 0, 1, 1, en_of(b), s, '0);
        expect_read(b, beat_addr(s, 0, m), r);
        for (int k = 1; k < nbeats; k++) begin
            cyc(1, 1, 0, 1, 2'b11, 0, '0);
            expect_read(b, beat_addr(s, k, m), r);
        end
    endtask

    task automatic t_reset();
        rst_n = 0; pstrb_n = 1; cstrb_n = 1; adv_n = 1; wr_n = 1;
        en_n = 2'b11; addr = '0; din = '0; order_sel = 0; oe_n = 0; sleep = 2'b00;
        repeat (3) @(posedge clk);
        #1 expect_quiet("R1 in reset");
        @(negedge clk) rst_n = 1;
        cyc(1, 1, 0, 1, 2'b11, 0, '0);
        expect_quiet("R1 advance without burst");
        cyc(1, 1, 1, 0, 2'b11, 0, pat(0, 0, 99));
        expect_quiet("R1 hold without burst");
    endtask

    task automatic t_linear();
        wr_burst(0, 'h09, 0, 'h10, "R3 R5 linear write");
        rd_burst(0, 'h09, 0, 4, 1, "R7 linear read");
        chk(dout[71:64] === ref_mem[0]['h08][71:64], "R11 parity bits",
            WW'(dout[71:64]), WW'(ref_mem[0]['h08][71:64]));
        chk(dout[15:8] === ref_mem[0]['h08][15:8], "R11 data byte 1",
            WW'(dout[15:8]), WW'(ref_mem[0]['h08][15:8]));
        cyc(1, 1, 0, 1, 2'b11, 0, '0);
        expect_read(0, 'h09, "R9 fifth beat wraps to start");
    endtask

    task automatic t_interleave();
        wr_burst(0, 'h12, 1, 'h20, "R8 interleaved write");
        rd_burst(0, 'h10, 0, 4, 1, "R8 interleaved placement");
        rd_burst(0, 'h13, 1, 4, 0, "R8 interleaved read R3");
    endtask

    task automatic t_suspend();
        order_sel = 0;
        cyc(0, 1, 1, 1, en_of(0), 'h10, '0);
        expect_read(0, 'h10, "R6 first beat");
        cyc(1, 1, 1, 1, 2'b11, 0, '0);
        expect_read(0, 'h10, "R6 hold keeps word");
        cyc(1, 1, 1, 1, 2'b11, 0, '0);
        expect_read(0, 'h10, "R6 second hold");
        cyc(1, 1, 0, 1, 2'b11, 0, '0);
        expect_read(0, 'h11, "R5 advance after hold");
        cyc(1, 1, 1, 0, 2'b11, 0, pat(0, 'h11, 'h33));
        ref_mem[0]['h11] = pat(0, 'h11, 'h33);
        cyc(1, 1, 1, 1, 2'b11, 0, '0);
        expect_read(0, 'h11, "R6 write on hold beat");
    endtask

    task automatic t_proc_ignores_write();
        cyc(0, 1, 1, 0, en_of(0), 'h09, pat(0, 'h09, 'hEE));
        expect_read(0, 'h09, "R2 processor strobe ignores write");
    endtask

    task automatic t_deselect();
        rd_burst(0, 'h09, 0, 1, 1, "R2 read before deselect");
        cyc(1, 0, 1, 1, 2'b11, 'h09, '0);
        expect_quiet("R4 deselect undriven");
        cyc(1, 1, 0, 1, 2'b11, 0, '0);
        expect_quiet("R4 advance after deselect");
        cyc(1, 1, 0, 0, 2'b11, 0, pat(0, 'h0A, 'h77));
        expect_quiet("R4 write after deselect");
        rd_burst(0, 'h0A, 0, 1, 1, "R4 nothing stored after deselect");
    endtask

    task automatic t_oe();
        rd_burst(0, 'h09, 0, 1, 1, "R10 read");
        oe_n = 1; #1;
        expect_quiet("R10 oe high undriven");
        oe_n = 0; #1;
        expect_read(0, 'h09, "R10 oe low driven again");
    endtask

    task automatic t_banks();
        wr_burst(1, 'h08, 0, 'h50, "R13 bank1 write");
        rd_burst(0, 'h08, 0, 4, 1, "R13 bank0 unchanged");
        rd_burst(1, 'h08, 0, 4, 0, "R13 bank1 kept across beats");
        cyc(1, 1, 0, 1, 2'b10, 0, '0);
        expect_read(1, 'h08, "R13 bank kept despite enable change");
    endtask

    task automatic t_sleep();
        wr_burst(1, 'h20, 0, 'h40, "R12 prefill");
        sleep[1] = 1'b1;
        wr_burst(1, 'h20, 0, 'h70, "R12 write while asleep");
        rd_burst(0, 'h08, 0, 1, 1, "R12 other bank awake");
        cyc(0, 1, 1, 1, en_of(1), 'h20, '0);
        expect_quiet("R12 asleep undriven");
        sleep[1] = 1'b0; #1;
        expect_read(1, 'h20, "R12 wake shows old word");
    endtask

    initial begin
        t_reset();
        t_linear();
        t_interleave();
        t_suspend();
        t_proc_ignores_write();
        t_deselect();
        t_oe();
        t_banks();
        t_sleep();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule